// File: doc/BRIEF.md
# Ping-Pong Frame Buffer for an In-Place FFT Engine

This block holds complex input frames of N samples for an in-place radix-2 FFT engine. It has two identical banks. One bank faces the host and fills with the next frame. The other bank faces the engine and serves as its working memory. Each bank is split into an even-index memory and an odd-index memory, each N/2 words deep. The engine can therefore read or write a pair of complex samples (2k, 2k+1) in a single clock, which is 4×B bits per clock.

The host streams samples over a valid/ready interface. A sample is taken on any rising clock edge where `in_valid` and `in_ready` are both high. Back-pressure happens once per frame. `in_ready` falls after the N-th sample is stored and stays low until the banks swap. The host may offer samples at any time while the engine is working. The banks swap roles when two conditions hold together: the host bank is full and the engine is idle. On the swap the block pulses `eng_start`, and the engine port then addresses the bank that was just filled.

Top module: `fft_pingpong_buf`

## Requirements
- R1: After reset, `in_ready` is 1, `eng_start` is 0 and `host_bank` is 0 (bank 0 faces the host). Both banks are marked not full.
- R2: `in_ready` stays high while the host bank holds fewer than N samples. It goes low on the clock edge that stores the N-th sample.
- R3: A sample offered with `in_valid` high while `in_ready` is low is not stored, and it does not shift the index of later samples.
- R4: The sample with frame index i goes into the even memory if i is even and into the odd memory if i is odd, at word address i/2. An engine read of address k returns sample 2k on `eng_rd_even` and sample 2k+1 on `eng_rd_odd`. Each returned word is {re, im}, with re in the upper B bits.
- R5: A swap never happens while the host bank holds fewer than N samples, even when the engine is idle.
- R6: While the engine is busy (between `eng_start` and `eng_done`), `host_bank` does not change, even when the host bank is full.
- R7: On a swap, `host_bank` toggles and `eng_start` is high for exactly one cycle, in the same cycle as the new `host_bank` value.
- R8: The engine port always addresses the bank that is not facing the host. Reads have one cycle of latency. A write with `eng_we` high stores both words of a pair at `eng_addr` in one clock. Host loading leaves the engine bank unchanged.
- R9: Directly after a swap `in_ready` is high, so the host can load the next frame while the engine is busy.
- R10: After a swap the host sample index starts again at zero, so the first sample of the next frame lands at even address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host sample valid |
| in_ready | output | 1 | Host bank can accept a sample |
| in_re | input | B | Real part of host sample |
| in_im | input | B | Imaginary part of host sample |
| host_bank | output | 1 | Index of the bank facing the host |
| eng_start | output | 1 | One-cycle pulse: a full frame is ready for the engine |
| eng_done | input | 1 | Engine finished the current frame (pulse) |
| eng_addr | input | log2(N/2) | Engine pair address |
| eng_we | input | 1 | Engine writes a pair at `eng_addr` |
| eng_wr_even | input | 2B | Engine write word for even sample {re, im} |
| eng_wr_odd | input | 2B | Engine write word for odd sample {re, im} |
| eng_rd_even | output | 2B | Even sample at the previous cycle's `eng_addr` |
| eng_rd_odd | output | 2B | Odd sample at the previous cycle's `eng_addr` |

## Verification
The assertions check the swap rules on every cycle:
- a swap only happens after `in_ready` was low;
- `host_bank` holds steady while the engine is busy;
- `eng_start` is a single pulse that coincides with the toggle;
- `in_ready` falls after the N-th sample and is high again right after a swap.

Only the bench scenarios can show where each sample ends up in the memories. These scenarios cover even/odd placement, rejected samples that leave no trace, the index restart after a swap, and engine writes that survive host loading. They do this by reading frames back through the engine port.

// File: rtl/fftbuf_pkg.sv
`timescale 1ns/1ps
package fftbuf_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_id_e;
  localparam int NUM_BANKS = 2;
  localparam int NUM_HALVES = 2;
endpackage

// File: rtl/fftbuf_sample_mem.sv
`timescale 1ns/1ps
module fftbuf_sample_mem #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fftbuf_bank.sv
`timescale 1ns/1ps
module fftbuf_bank #(
  parameter int N = 16,
  parameter int B = 8,
  localparam int HALF = N / 2,
  localparam int AW   = $clog2(HALF),
  localparam int IW   = $clog2(N),
  localparam int W    = 2 * B
) (
  input  logic          clk,
  input  logic          is_host,
  input  logic          h_we,
  input  logic [IW-1:0] h_idx,
  input  logic [W-1:0]  h_data,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [W-1:0]  e_wdata_even,
  input  logic [W-1:0]  e_wdata_odd,
  output logic [W-1:0]  e_rdata_even,
  output logic [W-1:0]  e_rdata_odd
);
  logic [W-1:0] rd [fftbuf_pkg::NUM_HALVES];

  for (genvar p = 0; p < fftbuf_pkg::NUM_HALVES; p++) begin : g_half
    logic          we_p;
    logic [AW-1:0] waddr_p;
    logic [W-1:0]  wdata_p;

    always_comb begin
      if (is_host) begin
        we_p    = h_we && (h_idx[0] == 1'(p));
        waddr_p = h_idx[IW-1:1];
        wdata_p = h_data;
      end else begin
        we_p    = e_we;
        waddr_p = e_addr;
        wdata_p = (p == 0) ? e_wdata_even : e_wdata_odd;
      end
    end

    fftbuf_sample_mem #(.DEPTH(HALF), .W(W)) u_mem (
      .clk  (clk),
      .we   (we_p),
      .waddr(waddr_p),
      .wdata(wdata_p),
      .raddr(e_addr),
      .rdata(rd[p])
    );
  end

  assign e_rdata_even = rd[0];
  assign e_rdata_odd  = rd[1];
endmodule

// File: rtl/fftbuf_ctrl.sv
`timescale 1ns/1ps
module fftbuf_ctrl #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          eng_done,
  output logic          in_ready,
  output logic          accept,
  output logic [IW-1:0] wr_idx,
  output logic          host_sel,
  output logic          eng_start
);
  logic [IW-1:0] cnt;
  logic [fftbuf_pkg::NUM_BANKS-1:0] full;
  logic busy;
  logic swap;

  assign in_ready = !full[host_sel];
  assign accept   = in_valid && in_ready;
  assign wr_idx   = cnt;
  assign swap     = full[host_sel] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      full      <= '0;
      host_sel  <= fftbuf_pkg::BANK_A;
      busy      <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= swap;
      if (accept) begin
        cnt <= cnt + 1'b1;
        if (cnt == IW'(N - 1)) full[host_sel] <= 1'b1;
      end
      if (swap) begin
        host_sel        <= ~host_sel;
        full[~host_sel] <= 1'b0;
        cnt             <= '0;
        busy            <= 1'b1;
      end else if (eng_done) begin
        busy <= 1'b0;
      end
    end
  end

  p_full_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt == IW'(N - 1)) |=> !in_ready);

  p_swap_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel != $past(host_sel)) |-> !$past(in_ready));

  p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> $stable(host_sel));

  p_start_with_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (host_sel != $past(host_sel)));

  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
endmodule

// File: rtl/fft_pingpong_buf.sv
`timescale 1ns/1ps
module fft_pingpong_buf #(
  parameter int N = 16,
  parameter int B = 8,
  localparam int AW = $clog2(N / 2),
  localparam int IW = $clog2(N),
  localparam int W  = 2 * B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [B-1:0]  in_re,
  input  logic [B-1:0]  in_im,
  output logic          host_bank,
  output logic          eng_start,
  input  logic          eng_done,
  input  logic [AW-1:0] eng_addr,
  input  logic          eng_we,
  input  logic [W-1:0]  eng_wr_even,
  input  logic [W-1:0]  eng_wr_odd,
  output logic [W-1:0]  eng_rd_even,
  output logic [W-1:0]  eng_rd_odd
);
  logic          accept;
  logic [IW-1:0] wr_idx;
  logic          sel;
  logic [W-1:0]  rd_even [fftbuf_pkg::NUM_BANKS];
  logic [W-1:0]  rd_odd  [fftbuf_pkg::NUM_BANKS];

  fftbuf_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .eng_done (eng_done),
    .in_ready (in_ready),
    .accept   (accept),
    .wr_idx   (wr_idx),
    .host_sel (sel),
    .eng_start(eng_start)
  );

  for (genvar b = 0; b < fftbuf_pkg::NUM_BANKS; b++) begin : g_bank
    fftbuf_bank #(.N(N), .B(B)) u_bank (
      .clk         (clk),
      .is_host     (sel == 1'(b)),
      .h_we        (accept),
      .h_idx       (wr_idx),
      .h_data      ({in_re, in_im}),
      .e_we        (eng_we),
      .e_addr      (eng_addr),
      .e_wdata_even(eng_wr_even),
      .e_wdata_odd (eng_wr_odd),
      .e_rdata_even(rd_even[b]),
      .e_rdata_odd (rd_odd[b])
    );
  end

  assign host_bank   = sel;
  assign eng_rd_even = sel ? rd_even[0] : rd_even[1];
  assign eng_rd_odd  = sel ? rd_odd[0]  : rd_odd[1];

  p_host_free_after_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> in_ready);
endmodule

// File: tb/tb_fft_pingpong_buf.sv
`timescale 1ns/1ps
module tb_fft_pingpong_buf;
  localparam int N  = 16;
  localparam int B  = 8;
  localparam int AW = $clog2(N / 2);
  localparam int W  = 2 * B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [B-1:0]  in_re = '0;
  logic [B-1:0]  in_im = '0;
  logic          host_bank;
  logic          eng_start;
  logic          eng_done = 1'b0;
  logic [AW-1:0] eng_addr = '0;
  logic          eng_we = 1'b0;
  logic [W-1:0]  eng_wr_even = '0;
  logic [W-1:0]  eng_wr_odd = '0;
  logic [W-1:0]  eng_rd_even;
  logic [W-1:0]  eng_rd_odd;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fft_pingpong_buf #(.N(N), .B(B)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .host_bank(host_bank), .eng_start(eng_start),
    .eng_done(eng_done), .eng_addr(eng_addr), .eng_we(eng_we),
    .eng_wr_even(eng_wr_even), .eng_wr_odd(eng_wr_odd),
    .eng_rd_even(eng_rd_even), .eng_rd_odd(eng_rd_odd)
  );

  function automatic logic [W-1:0] samp(input int f, input int i);
    logic [B-1:0] re;
    re = B'(f * 32 + i);
    return {re, B'(8'd255 - re)};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input int f, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      in_valid = 1'b1;
      {in_re, in_im} = samp(f, i);
      chk(in_ready == 1'b1, "R2 ready while filling", int'(in_ready), 1);
      @(negedge clk);
    end
  endtask

  task automatic read_frame(input int f, input string req);
    for (int k = 0; k < N / 2; k++) begin
      eng_addr = AW'(k);
      @(negedge clk);
      chk(eng_rd_even == samp(f, 2 * k), req, int'(eng_rd_even), int'(samp(f, 2 * k)));
      chk(eng_rd_odd == samp(f, 2 * k + 1), req, int'(eng_rd_odd), int'(samp(f, 2 * k + 1)));
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(eng_start == 1'b0, "R1 start", int'(eng_start), 0);
    chk(host_bank == 1'b0, "R1 bank", int'(host_bank), 0);
  endtask

  task automatic t_first_frame();
    push(0, 0, N - 1);
    chk(in_ready == 1'b0, "R2 ready low when full", int'(in_ready), 0);
    chk(eng_start == 1'b0, "R7 no start yet", int'(eng_start), 0);
    {in_re, in_im} = 16'hDEAD;
    @(negedge clk);
    in_valid = 1'b0;
    chk(eng_start == 1'b1, "R7 start pulse", int'(eng_start), 1);
    chk(host_bank == 1'b1, "R7 bank toggled", int'(host_bank), 1);
    chk(in_ready == 1'b1, "R9 ready after swap", int'(in_ready), 1);
    @(negedge clk);
    chk(eng_start == 1'b0, "R7 single pulse", int'(eng_start), 0);
    read_frame(0, "R4 frame0 placement");
  endtask

  task automatic t_load_while_busy();
    push(1, 0, N - 1);
    {in_re, in_im} = 16'hBEEF;
    for (int c = 0; c < 5; c++) begin
      chk(in_ready == 1'b0, "R3 ready low, junk offered", int'(in_ready), 0);
      chk(host_bank == 1'b1, "R6 no swap while busy", int'(host_bank), 1);
      chk(eng_start == 1'b0, "R6 no start while busy", int'(eng_start), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    read_frame(0, "R8 engine bank unchanged by host load");
  endtask

  task automatic t_engine_write();
    eng_we = 1'b1; eng_addr = AW'(3);
    eng_wr_even = 16'h1234; eng_wr_odd = 16'h5678;
    @(negedge clk);
    eng_we = 1'b0;
    @(negedge clk);
    chk(eng_rd_even == 16'h1234, "R8 engine write even", int'(eng_rd_even), 'h1234);
    chk(eng_rd_odd == 16'h5678, "R8 engine write odd", int'(eng_rd_odd), 'h5678);
    eng_addr = AW'(2);
    @(negedge clk);
    chk(eng_rd_even == samp(0, 4), "R8 neighbour intact", int'(eng_rd_even), int'(samp(0, 4)));
  endtask

  task automatic t_done_swap();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk(eng_start == 1'b0, "R7 start follows swap", int'(eng_start), 0);
    chk(host_bank == 1'b1, "R6 bank held until swap", int'(host_bank), 1);
    @(negedge clk);
    chk(eng_start == 1'b1, "R7 start after done", int'(eng_start), 1);
    chk(host_bank == 1'b0, "R7 bank toggled back", int'(host_bank), 0);
    chk(in_ready == 1'b1, "R9 ready after second swap", int'(in_ready), 1);
    @(negedge clk);
    read_frame(1, "R10 R3 frame1 restart at index 0, junk not stored");
  endtask

  task automatic t_partial_no_swap();
    push(2, 0, 4);
    in_valid = 1'b0;
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    for (int c = 0; c < 4; c++) begin
      chk(eng_start == 1'b0, "R5 no start on partial frame", int'(eng_start), 0);
      chk(host_bank == 1'b0, "R5 no swap on partial frame", int'(host_bank), 0);
      chk(in_ready == 1'b1, "R2 ready on partial frame", int'(in_ready), 1);
      @(negedge clk);
    end
    push(2, 5, N - 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk(eng_start == 1'b1, "R5 swap once full", int'(eng_start), 1);
    chk(host_bank == 1'b1, "R5 bank toggled", int'(host_bank), 1);
    @(negedge clk);
    read_frame(2, "R4 frame2 over earlier engine write");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_frame();
    t_load_while_busy();
    t_engine_write();
    t_done_swap();
    t_partial_no_swap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule